// File: doc/BRIEF.md
# Absolute Time Base with Pulse-Synchronised Load

This block keeps wall-clock time as a whole-seconds count and a sub-second tick count that advances once per clock. New seconds and ticks values are staged through a small write-only register port. The staged pair is applied as a single 64-bit update: either one cycle after the load is armed, or on the first qualifying edge of a once-per-second pulse.

The pulse is taken from one of two pins. Each pin goes through its own synchroniser, and a flag chooses which pin counts and whether its rising or its falling edge is the event. Every qualifying edge raises a one-cycle `pps_seen` strobe, whether or not a load is armed. Timestamping logic elsewhere in the chip reads `time_now` directly.

Top module: `abs_time_keeper`

## Requirements
- R1: While `rst_n` is low, `time_now` is zero and `pps_seen` is low. The edge flag, the source flag and the load mode all reset to 0, and no load is armed.
- R2: Each clock adds one to the ticks field (bits 31:0). On the edge where ticks equal TICKS_PER_SEC-1, ticks return to 0 and the seconds field (bits 63:32) adds one.
- R3: If a loaded ticks value is at or above TICKS_PER_SEC-1, ticks go to 0 and the seconds field adds one on the next edge.
- R4: A write to address 0 stages seconds and a write to address 1 stages ticks. Neither write changes `time_now` until a load happens.
- R5: A write to address 2 sets the flags: bit 0 selects the edge (0 falling, 1 rising) and bit 1 selects the pin (0 `pps_a`, 1 `pps_b`).
- R6: A write to address 3 arms a load. If `cfg_wdata` bit 0 is 1, the staged time appears on `time_now` after the second clock edge counted from the write edge.
- R7: If address 3 is written with bit 0 equal to 0, the staged time is loaded on the first qualifying pulse edge after the write, and the load then disarms. Later edges leave the count running.
- R8: An edge of the wrong polarity, or any edge on the pin that is not selected, produces neither a strobe nor a load.
- R9: Suppose a qualifying level change is sampled at clock edge E1. Then `pps_seen` is high for exactly one cycle after edge E2, and an armed pulse load takes effect at edge E3.
- R10: If a load lands on the same edge as a tick rollover, the load wins: `time_now` takes the staged value, not the carried seconds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; ticks advance once per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 seconds, 1 ticks, 2 flags, 3 arm/mode |
| cfg_wdata | input | DATA_W (32) | Register write data |
| pps_a | input | 1 | First asynchronous pulse pin |
| pps_b | input | 1 | Second asynchronous pulse pin |
| time_now | output | SECS_W+TICKS_W (64) | Current time, {seconds, ticks} |
| pps_seen | output | 1 | One-cycle strobe on each qualifying pulse edge |

## Verification
A load and a tick rollover can fall on the same clock edge. The bench provokes this by arming an immediate load at the moment the count reaches TICKS_PER_SEC-2, so that the load edge is the rollover edge. It passes only if `time_now` shows the staged pair and not the carried seconds. The bench also fires pulse edges when nothing is armed and checks that the strobe still appears while the count runs on without a jump.

// File: rtl/time_pkg.sv
package time_pkg;
   localparam int CFG_ADDR_W = 2;

   // register select codes
   localparam logic [CFG_ADDR_W-1:0] ADDR_SECS  = 2'd0;
   localparam logic [CFG_ADDR_W-1:0] ADDR_TICKS = 2'd1;
   localparam logic [CFG_ADDR_W-1:0] ADDR_FLAGS = 2'd2;
   localparam logic [CFG_ADDR_W-1:0] ADDR_ARM   = 2'd3;

   // flag bit positions
   localparam int FLG_RISE = 0;
   localparam int FLG_SRC  = 1;

   typedef struct packed {
      logic src_b;   // 1: second pulse pin
      logic rise;    // 1: rising edge qualifies
   } pps_cfg_t;
endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pps_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/pps_edge_unit.sv
module pps_edge_unit
   import time_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pps_a,
   input  logic     pps_b,
   input  pps_cfg_t cfg,
   output logic     pps_evt
);
   localparam int N_SRC = 2;

   logic [N_SRC-1:0] raw;
   logic [N_SRC-1:0] synced;
   logic             cur;
   logic             prev;
   logic             rise_det;
   logic             fall_det;

   assign raw = {pps_b, pps_a};

   for (genvar g = 0; g < N_SRC; g++) begin : g_sync
      pps_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (raw[g]),
         .q     (synced[g])
      );
   end

   assign cur = cfg.src_b ? synced[1] : synced[0];

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= cur;
   end

   assign rise_det = cur & ~prev;
   assign fall_det = ~cur & prev;
   assign pps_evt  = cfg.rise ? rise_det : fall_det;

   // R9
   pps_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pps_evt |=> (!pps_evt || (cfg != $past(cfg))));
endmodule

// File: rtl/time_cfg_regs.sv
module time_cfg_regs
   import time_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SECS_W  = 32,
   parameter int TICKS_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [CFG_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic                  pps_evt,
   output logic [SECS_W-1:0]     stg_secs,
   output logic [TICKS_W-1:0]    stg_ticks,
   output pps_cfg_t              cfg,
   output logic                  load
);
   logic imm_mode;
   logic armed;
   logic arm_wr;

   assign arm_wr = we && (addr == ADDR_ARM);
   assign load   = armed && (imm_mode || pps_evt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_secs  <= '0;
         stg_ticks <= '0;
         cfg       <= '0;
         imm_mode  <= 1'b0;
      end else if (we) begin
         unique case (addr)
            ADDR_SECS:  stg_secs  <= wdata[SECS_W-1:0];
            ADDR_TICKS: stg_ticks <= wdata[TICKS_W-1:0];
            ADDR_FLAGS: cfg       <= '{src_b: wdata[FLG_SRC], rise: wdata[FLG_RISE]};
            ADDR_ARM:   imm_mode  <= wdata[0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      armed <= 1'b0;
      else if (arm_wr) armed <= 1'b1;
      else if (load)   armed <= 1'b0;
   end

   // R7
   arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm_wr |=> armed);

   // R7
   arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !arm_wr) |=> !armed);
endmodule

// File: rtl/time_counter.sv
module time_counter #(
   parameter int SECS_W        = 32,
   parameter int TICKS_W       = 32,
   parameter int TICKS_PER_SEC = 100_000_000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [SECS_W-1:0]  ld_secs,
   input  logic [TICKS_W-1:0] ld_ticks,
   output logic [SECS_W-1:0]  secs,
   output logic [TICKS_W-1:0] ticks
);
   localparam logic [TICKS_W-1:0] LAST_TICK = TICKS_W'(TICKS_PER_SEC - 1);

   if (TICKS_PER_SEC < 2) begin : g_bad_rate
      $error("time_counter: TICKS_PER_SEC must be at least 2");
   end
   if (TICKS_W < 31 && TICKS_PER_SEC > (1 << TICKS_W)) begin : g_bad_width
      $error("time_counter: TICKS_W too narrow for TICKS_PER_SEC");
   end

   logic at_last;
   assign at_last = (ticks >= LAST_TICK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         secs  <= '0;
         ticks <= '0;
      end else if (load) begin
         secs  <= ld_secs;
         ticks <= ld_ticks;
      end else if (at_last) begin
         secs  <= secs + SECS_W'(1);
         ticks <= '0;
      end else begin
         ticks <= ticks + TICKS_W'(1);
      end
   end

   // R2
   tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && ticks < LAST_TICK) |=> (ticks == $past(ticks) + TICKS_W'(1)) && $stable(secs));

   // R3
   tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && ticks >= LAST_TICK) |=> (ticks == '0) && (secs == $past(secs) + SECS_W'(1)));

   // R10
   load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (secs == $past(ld_secs)) && (ticks == $past(ld_ticks)));
endmodule

// File: rtl/abs_time_keeper.sv
module abs_time_keeper
   import time_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int SECS_W        = 32,
   parameter int TICKS_W       = 32,
   parameter int TICKS_PER_SEC = 100_000_000,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [CFG_ADDR_W-1:0]     cfg_addr,
   input  logic [DATA_W-1:0]         cfg_wdata,
   input  logic                      pps_a,
   input  logic                      pps_b,
   output logic [SECS_W+TICKS_W-1:0] time_now,
   output logic                      pps_seen
);
   if (SECS_W > DATA_W || TICKS_W > DATA_W) begin : g_bad_data
      $error("abs_time_keeper: SECS_W and TICKS_W must not exceed DATA_W");
   end

   pps_cfg_t           cfg;
   logic               pps_evt;
   logic               load;
   logic [SECS_W-1:0]  stg_secs;
   logic [TICKS_W-1:0] stg_ticks;
   logic [SECS_W-1:0]  secs;
   logic [TICKS_W-1:0] ticks;

   pps_edge_unit #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .pps_a   (pps_a),
      .pps_b   (pps_b),
      .cfg     (cfg),
      .pps_evt (pps_evt)
   );

   time_cfg_regs #(.DATA_W(DATA_W), .SECS_W(SECS_W), .TICKS_W(TICKS_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .addr      (cfg_addr),
      .wdata     (cfg_wdata),
      .pps_evt   (pps_evt),
      .stg_secs  (stg_secs),
      .stg_ticks (stg_ticks),
      .cfg       (cfg),
      .load      (load)
   );

   time_counter #(.SECS_W(SECS_W), .TICKS_W(TICKS_W), .TICKS_PER_SEC(TICKS_PER_SEC)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .ld_secs  (stg_secs),
      .ld_ticks (stg_ticks),
      .secs     (secs),
      .ticks    (ticks)
   );

   assign time_now = {secs, ticks};
   assign pps_seen = pps_evt;
endmodule

// File: tb/abs_time_keeper_tb_top.sv
module abs_time_keeper_tb_top;
   localparam int TPS = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic        pps_a = 1'b0;
   logic        pps_b = 1'b0;
   logic [63:0] time_now;
   logic        pps_seen;

   int total = 0;
   int bad = 0;
   logic [31:0] stg_s = 32'd0;
   logic [31:0] stg_t = 32'd0;

   always #5ns clk = ~clk;

   abs_time_keeper #(.TICKS_PER_SEC(TPS)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .pps_a     (pps_a),
      .pps_b     (pps_b),
      .time_now  (time_now),
      .pps_seen  (pps_seen)
   );

   function automatic logic [63:0] adv(input logic [63:0] t, input int n);
      logic [63:0] r = t;
      for (int i = 0; i < n; i++) begin
         if (r[31:0] >= 32'(TPS - 1)) r = {r[63:32] + 32'd1, 32'd0};
         else                         r = {r[63:32], r[31:0] + 32'd1};
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // called at a negedge, returns at the next negedge
   task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic stage(input logic [31:0] s, input logic [31:0] t);
      cfg_write(2'd0, s);
      cfg_write(2'd1, t);
      stg_s = s; stg_t = t;
   endtask

   task automatic pps_step(input logic use_b, input logic lvl, input logic exp_seen,
                           input logic exp_load, input string req);
      logic [63:0] t0 = time_now;
      if (use_b) pps_b = lvl; else pps_a = lvl;
      @(negedge clk);
      chk({req, " strobe after E1"}, {63'd0, pps_seen}, 64'd0);
      @(negedge clk);
      chk({req, " strobe after E2"}, {63'd0, pps_seen}, {63'd0, exp_seen});
      @(negedge clk);
      chk({req, " strobe after E3"}, {63'd0, pps_seen}, 64'd0);
      chk({req, " time after E3"}, time_now, exp_load ? {stg_s, stg_t} : adv(t0, 3));
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1 time in reset", time_now, 64'd0);
      chk("R1 strobe in reset", {63'd0, pps_seen}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 first count after reset", time_now, 64'd1);
   endtask

   task automatic t_count();
      logic [63:0] t;
      int wraps = 0;
      for (int i = 0; i < 2 * TPS + 5; i++) begin
         t = time_now;
         @(negedge clk);
         if (t[31:0] == 32'(TPS - 1)) wraps++;
         chk("R2 tick step", time_now, adv(t, 1));
      end
      chk("R2 rollovers seen", 64'(wraps), 64'd2);
   endtask

   task automatic t_stage_only();
      logic [63:0] t = time_now;
      stage(32'h0000_1234, 32'd7);
      chk("R4 staging leaves time", time_now, adv(t, 2));
      repeat (3) @(negedge clk);
      chk("R4 still counting", time_now, adv(t, 5));
   endtask

   task automatic t_immediate();
      stage(32'h0000_5000, 32'd11);
      cfg_write(2'd3, 32'd1);
      @(negedge clk);
      chk("R6 immediate load", time_now, {stg_s, stg_t});
      @(negedge clk);
      chk("R6 count after load", time_now, {stg_s, 32'd12});
   endtask

   task automatic t_big_ticks();
      stage(32'h0000_0077, 32'd100);
      cfg_write(2'd3, 32'd1);
      @(negedge clk);
      chk("R3 oversized load", time_now, {32'h77, 32'd100});
      @(negedge clk);
      chk("R3 oversized wraps", time_now, {32'h78, 32'd0});
   endtask

   task automatic t_pps_default();
      cfg_write(2'd2, 32'd0);
      stage(32'h0000_0A0A, 32'd3);
      cfg_write(2'd3, 32'd0);
      pps_step(1'b0, 1'b1, 1'b0, 1'b0, "R8 rising ignored in falling mode");
      pps_step(1'b0, 1'b0, 1'b1, 1'b1, "R7 R9 falling edge loads");
      pps_step(1'b0, 1'b1, 1'b0, 1'b0, "R8 rising ignored again");
      pps_step(1'b0, 1'b0, 1'b1, 1'b0, "R7 disarmed, strobe only");
   endtask

   task automatic t_pps_rise_b();
      cfg_write(2'd2, 32'd3);
      stage(32'h0000_0B0B, 32'd9);
      cfg_write(2'd3, 32'd0);
      pps_step(1'b0, 1'b1, 1'b0, 1'b0, "R8 unselected pin rising");
      pps_step(1'b0, 1'b0, 1'b0, 1'b0, "R8 unselected pin falling");
      pps_step(1'b1, 1'b1, 1'b1, 1'b1, "R5 R9 rising edge on second pin loads");
      pps_step(1'b1, 1'b0, 1'b0, 1'b0, "R5 falling ignored in rising mode");
   endtask

   task automatic t_load_vs_wrap();
      stage(32'h0000_0C0C, 32'd20);
      while (time_now[31:0] != 32'(TPS - 2)) @(negedge clk);
      cfg_write(2'd3, 32'd1);
      chk("R10 at last tick", {32'd0, time_now[31:0]}, 64'(TPS - 1));
      @(negedge clk);
      chk("R10 load beats rollover", time_now, {stg_s, stg_t});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_count();
      t_stage_only();
      t_immediate();
      t_big_ticks();
      t_pps_default();
      t_pps_rise_b();
      t_load_vs_wrap();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule